// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable, register-based model of a synchronous static memory with pipelined reads and short bursts. The array is built from 36-bit words, each made of four 9-bit lanes (8 data bits and 1 parity bit per lane). Address and control are taken on the rising clock edge. Writes finish at the edge that captures them, with no handshake.

A burst opens with either of two active-low address strobes. The processor strobe always opens a read. The controller strobe opens a read or a write. Each later access in the burst uses an address that a 2-bit counter produces inside the block. The counter moves only in cycles where the step input is low. In every other cycle the current address is held. A mode input picks between a linear and an interleaved order for the low two address bits. Three chip enables must all be active for the device to be selected. Read data passes through two register stages. The output enable gates the data combinationally. The sleep input stops all accesses while leaving the stored words as they are.

Top module: `sync_burst_sram`

## Requirements
- R1: The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A cycle that carries an accepted strobe while any enable is inactive is a deselect. `dq_drive` is low after the second rising edge that follows it. A read already in flight still appears after the first edge.
- R2: A read captured at rising edge E appears on `dout` with `dq_drive`=1 after edge E+1. After reset, `dq_drive`=0 and `dout`=0.
- R3: With linear order (`order_sel`=0), the low two address bits of burst access k are (start + k) mod 4. The upper address bits stay at the starting value.
- R4: With interleaved order (`order_sel`=1), the low two address bits of burst access k are start XOR k.
- R5: A change of `order_sel` first affects the burst address computed at the edge after the one that captures the change.
- R6: When `all_wr_n`=0, all four lanes are written. Lane i occupies bits 9i+8 down to 9i.
- R7: When `all_wr_n`=1 and `lane_wr_en_n`=0, only the lanes whose `lane_wr_n` bit is 0 are written. When `lane_wr_en_n`=1 and `all_wr_n`=1, the cycle is a read and memory does not change.
- R8: A processor-strobe cycle with `sel_a_n`=1 is ignored. When both strobes are low, the processor strobe wins. A processor-strobe cycle is always a read, whatever the write inputs are.
- R9: The burst counter advances only in cycles with `step_n`=0. A cycle with no strobe and `step_n`=1 repeats the current address.
- R10: `out_en_n`=1 forces `dq_drive`=0 and `dout`=0 at once, with no clock edge needed.
- R11: While `sleep`=1, no read or write takes place, `dq_drive` is 0, and the stored contents are kept.
- R12: After four steps the counter wraps, and the burst returns to its starting address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control registers |
| addr | input | AW | Word address |
| sel_a_n | input | 1 | Chip enable A, active low; also qualifies the processor strobe |
| sel_b | input | 1 | Chip enable B, active high |
| sel_c_n | input | 1 | Chip enable C, active low |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 = linear burst order, 1 = interleaved |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_en_n | input | 1 | Per-lane write enable, active low |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Low-power hold |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero when not driven |
| dq_drive | output | 1 | High when the output would be driven |

## Verification
The checker watches three things on every cycle. First, the output stays dark whenever sleep is high or the output enable is off. Second, a deselect always turns the output off after two edges. Third, a selected processor-strobe read always brings the output up after the pipeline delay, unless sleep or the output enable prevents it. Other behaviours can only be shown by the bench's scenarios, with data compared against a reference array: the burst address orders, the delayed effect of a mode change, counter wrap and suspension, lane-selective writes, strobe priority, and the preservation of contents during sleep.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int W  = LANES * LANE_W,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             step_n,
  input  logic             order_sel,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             out_en_n,
  input  logic             sleep,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic             dq_drive
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] base_q, ra_q;
  logic [1:0]    cnt_q;
  logic          act_q, rd_q, vld_q, order_q;
  logic [W-1:0]  dout_q;

  wire sel   = !sel_a_n && sel_b && !sel_c_n;
  wire p_go  = !proc_strobe_n && !sel_a_n;
  wire c_go  = !ctrl_strobe_n && !p_go;
  wire start = p_go || c_go;

  wire [LANES-1:0] lane_m = !all_wr_n ? '1 : (lane_wr_en_n ? '0 : ~lane_wr_n);
  wire wr_req = (|lane_m) && !p_go;

  wire [1:0]    cnt_n  = start ? 2'd0 : (!step_n ? 2'(cnt_q + 2'd1) : cnt_q);
  wire [AW-1:0] base_n = start ? addr : base_q;
  wire [1:0]    lo     = order_q ? (base_n[1:0] ^ cnt_n) : 2'(base_n[1:0] + cnt_n);
  wire [AW-1:0] acc    = {base_n[AW-1:2], lo};

  wire live  = !sleep && (start ? sel : act_q);
  wire do_wr = live && wr_req;
  wire do_rd = live && !wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      vld_q   <= 1'b0;
      order_q <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      ra_q    <= '0;
      dout_q  <= '0;
    end else begin
      order_q <= order_sel;
      vld_q   <= rd_q && !sleep;
      rd_q    <= do_rd;
      if (rd_q) dout_q <= mem[ra_q];
      if (do_rd) ra_q <= acc;
      if (!sleep) begin
        if (start) act_q <= sel;
        base_q <= base_n;
        cnt_q  <= cnt_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (do_wr && lane_m[i]) mem[acc][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
  end

  assign dq_drive = vld_q && !out_en_n && !sleep;
  assign dout     = dq_drive ? dout_q : '0;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int W = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel_a_n,
  input logic         sel_b,
  input logic         sel_c_n,
  input logic         proc_strobe_n,
  input logic         ctrl_strobe_n,
  input logic         out_en_n,
  input logic         sleep,
  input logic [W-1:0] dout,
  input logic         dq_drive
);
  wire chip_on  = !sel_a_n && sel_b && !sel_c_n;
  wire strobe   = (!proc_strobe_n && !sel_a_n) || !ctrl_strobe_n;
  wire desel    = !sleep && strobe && !chip_on;
  wire rd_start = !sleep && !proc_strobe_n && chip_on;

  AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_drive); // R11
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (!dq_drive && dout == '0)); // R10
  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> ##1 !dq_drive); // R1
  AST_READ_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start ##1 !sleep |=> (dq_drive || out_en_n || sleep)); // R2
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.W(W)) u_chk (.*);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int AW = 6;
  localparam int W  = 36;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr;
  logic sel_a_n, sel_b, sel_c_n, proc_strobe_n, ctrl_strobe_n, step_n, order_sel;
  logic all_wr_n, lane_wr_en_n, out_en_n, sleep;
  logic [3:0] lane_wr_n;
  logic [W-1:0] din, dout;
  logic dq_drive;

  sync_burst_sram uut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit fin = 0;
  logic [W-1:0] refm [64];

  // {addr, lane mask, global, data}
  localparam logic [46:0] VEC [8] = '{
    {6'd3,  4'b0001, 1'b0, 36'h1_1111_1111},
    {6'd3,  4'b1000, 1'b0, 36'hA_BBBB_BBBB},
    {6'd10, 4'b0110, 1'b0, 36'h0_F0F0_F0F0},
    {6'd11, 4'b0000, 1'b1, 36'h7_7777_7777},
    {6'd12, 4'b0101, 1'b0, 36'hE_DCBA_9876},
    {6'd13, 4'b1010, 1'b0, 36'h3_3333_3333},
    {6'd14, 4'b1111, 1'b0, 36'h2_4682_4682},
    {6'd15, 4'b0000, 1'b1, 36'hF_0000_000F}
  };

  function automatic logic [W-1:0] pat(int a);
    return {4'(a), 32'hC0DE_0000 | 32'(a * 257)};
  endfunction

  task automatic chk(string r, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    proc_strobe_n = 1; ctrl_strobe_n = 1; step_n = 1;
    all_wr_n = 1; lane_wr_en_n = 1; lane_wr_n = '1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [W-1:0] d, logic [3:0] m, bit glob);
    ctrl_strobe_n = 0; addr = a; din = d;
    if (glob) all_wr_n = 0; else begin lane_wr_en_n = 0; lane_wr_n = ~m; end
    tick();
    for (int i = 0; i < 4; i++)
      if (glob || m[i]) refm[a][i*9 +: 9] = d[i*9 +: 9];
    idle();
  endtask

  task automatic rd(logic [AW-1:0] a, string r);
    ctrl_strobe_n = 0; addr = a;
    tick();
    idle();
    tick();
    chk(r, dout, refm[a]);
    chk(r, W'(dq_drive), W'(1));
  endtask

  task automatic burst(logic [AW-1:0] b, bit il, string r);
    order_sel = il; tick();
    proc_strobe_n = 0; addr = b; tick();
    for (int k = 1; k <= 4; k++) begin
      idle();
      if (k < 4) step_n = 0;
      tick();
      if (il) chk(r, dout, refm[{b[AW-1:2], b[1:0] ^ 2'(k-1)}]);
      else    chk(r, dout, refm[{b[AW-1:2], 2'(b[1:0] + 2'(k-1))}]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog R2 act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(); order_sel = 0; out_en_n = 0; sleep = 0; addr = '0; din = '0;
    for (int a = 0; a < 64; a++) refm[a] = '0;
    tick(); tick();
    chk("R2 reset drive", W'(dq_drive), W'(0));
    chk("R2 reset dout", dout, '0);
    rst_n = 1; tick();

    for (int a = 0; a < 16; a++) wr(6'(a), pat(a), 4'hF, 1);
    rd(5, "R2 read");

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][46:41], VEC[i][35:0], VEC[i][40:37], VEC[i][36]);
      rd(VEC[i][46:41], VEC[i][36] ? "R6 global" : "R7 lanes");
    end

    ctrl_strobe_n = 0; addr = 3; lane_wr_en_n = 1; lane_wr_n = '0; din = '1;
    tick(); idle();
    rd(3, "R7 enable off");

    burst(9, 0, "R3 linear");
    burst(9, 1, "R4 interleaved");
    order_sel = 0; tick();

    proc_strobe_n = 0; addr = 5; tick();
    idle(); step_n = 0; order_sel = 1; tick(); chk("R5 old order", dout, refm[5]);
    idle(); step_n = 0; tick(); chk("R5 delayed", dout, refm[6]);
    idle(); step_n = 0; tick(); chk("R5 new order", dout, refm[7]);
    idle(); tick(); chk("R5 new order", dout, refm[6]);
    order_sel = 0; tick();

    proc_strobe_n = 0; addr = 12; tick();
    idle(); step_n = 0; tick(); chk("R9 first", dout, refm[12]);
    idle(); tick(); chk("R9 step", dout, refm[13]);
    idle(); step_n = 0; tick(); chk("R9 held", dout, refm[13]);
    idle(); tick(); chk("R9 resume", dout, refm[14]);

    proc_strobe_n = 0; addr = 7; tick();
    for (int k = 0; k < 4; k++) begin
      idle(); step_n = 0; tick();
      chk("R12 seq", dout, refm[{4'd1, 2'(2'd3 + 2'(k))}]);
    end
    idle(); tick(); chk("R12 wrap", dout, refm[7]);

    rd(2, "R10 setup");
    out_en_n = 1; #1;
    chk("R10 off drive", W'(dq_drive), W'(0));
    chk("R10 off dout", dout, '0);
    out_en_n = 0; #1;
    chk("R10 back", dout, refm[2]);

    rd(4, "R1 setup");
    ctrl_strobe_n = 0; sel_b = 0; tick();
    chk("R1 in flight", W'(dq_drive), W'(1));
    idle(); tick();
    chk("R1 deselect b", W'(dq_drive), W'(0));
    rd(4, "R1 reselect");
    ctrl_strobe_n = 0; sel_c_n = 1; tick(); idle(); tick();
    chk("R1 deselect c", W'(dq_drive), W'(0));

    proc_strobe_n = 0; sel_a_n = 1; addr = 1; tick(); idle(); tick();
    chk("R8 ignored", W'(dq_drive), W'(0));
    proc_strobe_n = 0; ctrl_strobe_n = 0; addr = 2; all_wr_n = 0; din = 36'h5_5555_5555;
    tick(); idle(); tick();
    chk("R8 priority read", dout, refm[2]);
    rd(2, "R8 unchanged");

    rd(6, "R11 setup");
    sleep = 1; #1;
    chk("R11 dark", W'(dq_drive), W'(0));
    ctrl_strobe_n = 0; addr = 6; all_wr_n = 0; din = 36'h9_9999_9999;
    tick(); idle(); tick();
    chk("R11 still dark", W'(dq_drive), W'(0));
    sleep = 0;
    rd(6, "R11 kept");

    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule